// File: doc/BRIEF.md
# Battery-Backed Clock and Configuration Store Controller

This block is the host-side register front end for two small battery-backed stores. The first is a clock store of nibble-wide cells. The second is a byte-wide configuration memory. The host reaches both through one request strobe, a write flag, a two-bit register select and a 16-bit write bus. Read data comes back on an 8-bit registered output one cycle after the request.

The clock store uses a pointer register for its nibble address. Every data access, read or write, moves the pointer on by one, so a block of cells can be streamed without reloading the address. The configuration memory takes its byte address in inverted form. The block complements the value and keeps only the low bits that the memory depth needs. Data accesses to the memory leave that address unchanged.

A power-fail clear input covers supply ramp-up and ramp-down. While it is high, every write is dropped, reads return zero and move no pointer, and a registered battery-enable output asks the supply to keep both stores alive from the battery. Both storage arrays are inside the block and are written so that they map onto FPGA block RAM.

Top module: `bkup_store_ctrl`

## Requirements
- R1: While `rst` is high and after its release, `rdata` reads 0, `batt_en` reads 1, and the clock pointer and the memory address both hold 0.
- R2: A write with `sel`=0 loads `wdata[3:0]` into the clock pointer and ignores the upper bits. A read with `sel`=0 returns the pointer zero-extended on `rdata` in the following cycle.
- R3: A write with `sel`=1 stores `wdata[3:0]` in the clock cell at the pointer, then increments the pointer.
- R4: A read with `sel`=1 returns the clock cell at the pointer, zero-extended, on `rdata` in the following cycle, then increments the pointer.
- R5: The clock pointer increments from 15 to 0.
- R6: A write with `sel`=2 loads the memory address with the bitwise inverse of `wdata`, keeping only its low log2(MEM_DEPTH) bits.
- R7: A write with `sel`=3 stores `wdata[7:0]` at the memory address. A read with `sel`=3 returns that byte on `rdata` in the following cycle. Neither access changes the address.
- R8: While `ifc_clr` is high, writes to any of the four selects change no stored value, pointer or address.
- R9: While `ifc_clr` is high, a read returns 0 in the following cycle and does not move the clock pointer.
- R10: Outside reset, `batt_en` equals the value `ifc_clr` had one cycle earlier.
- R11: A read with `sel`=2 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifc_clr | input | 1 | Power-fail clear; blocks accesses |
| req | input | 1 | Access request strobe |
| we | input | 1 | 1 = write, 0 = read |
| sel | input | 2 | Register select: 0 clock pointer, 1 clock data, 2 memory address, 3 memory data |
| wdata | input | HOST_W (16) | Write data |
| rdata | output | MEM_W (8) | Read data, valid the cycle after a read |
| batt_en | output | 1 | Battery hold request |

## Verification
The bench keeps the 16-cell, 4-bit clock store and the 16-bit host bus, but shrinks the memory to 64 bytes. At that size every memory address can be written and read back. The bench does this with non-zero junk in the upper bits of the inverted address, which shows that only the low six decoded bits select a cell. The full clock store is streamed from a non-zero start pointer, so the increment from 15 to 0 occurs inside the stream. After the sweeps, every register is exercised under the power-fail clear.

// File: rtl/bk_pkg.sv
package bk_pkg;
  typedef enum logic [1:0] {
    SEL_NADDR = 2'd0,
    SEL_NDATA = 2'd1,
    SEL_MADDR = 2'd2,
    SEL_MDATA = 2'd3
  } bk_sel_e;
endpackage

// File: rtl/bk_nib_store.sv
module bk_nib_store #(
  parameter int DEPTH = 16,
  parameter int W     = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_ptr,
  input  logic [PW-1:0] ptr_in,
  input  logic          wr,
  input  logic          rd,
  input  logic [W-1:0]  wdata,
  output logic [PW-1:0] ptr,
  output logic [W-1:0]  q
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) cells[ptr] <= wdata;
    if (rd) q <= cells[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld_ptr) begin
      ptr <= ptr_in;
    end else if (wr || rd) begin
      ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + PW'(1);
    end
  end
endmodule

// File: rtl/bk_byte_store.sv
module bk_byte_store #(
  parameter int DEPTH = 2048,
  parameter int W     = 8,
  parameter int IN_W  = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_addr,
  input  logic [IN_W-1:0] addr_in,
  input  logic            wr,
  input  logic            rd,
  input  logic [W-1:0]    wdata,
  output logic [AW-1:0]   addr,
  output logic [W-1:0]    q
);
  logic [W-1:0]    bytes [DEPTH];
  logic [IN_W-1:0] addr_dec;
  logic            unused_hi;

  assign addr_dec  = ~addr_in;
  assign unused_hi = ^addr_dec[IN_W-1:AW];

  always_ff @(posedge clk) begin
    if (wr) bytes[addr] <= wdata;
    if (rd) q <= bytes[addr];
  end

  always_ff @(posedge clk) begin
    if (rst)          addr <= '0;
    else if (ld_addr) addr <= addr_dec[AW-1:0];
  end
endmodule

// File: rtl/bkup_store_ctrl.sv
module bkup_store_ctrl
  import bk_pkg::*;
#(
  parameter int CLK_DEPTH = 16,
  parameter int CLK_W     = 4,
  parameter int MEM_DEPTH = 2048,
  parameter int MEM_W     = 8,
  parameter int HOST_W    = 16,
  localparam int PW       = $clog2(CLK_DEPTH),
  localparam int AW       = $clog2(MEM_DEPTH),
  localparam int PAD_D    = MEM_W - CLK_W,
  localparam int PAD_P    = MEM_W - PW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ifc_clr,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [HOST_W-1:0] wdata,
  output logic [MEM_W-1:0]  rdata,
  output logic              batt_en
);
  bk_sel_e        sel_e;
  logic           go, wr_go, rd_go;
  logic [PW-1:0]  nib_ptr, ptr_snap;
  logic [CLK_W-1:0] nib_q;
  logic [AW-1:0]  mem_addr;
  logic [MEM_W-1:0] byte_q;
  bk_sel_e        sel_q;
  logic           blk_q;
  logic           unused_w;

  assign sel_e    = bk_sel_e'(sel);
  assign go       = req && !ifc_clr;
  assign wr_go    = go && we;
  assign rd_go    = go && !we;
  assign unused_w = ^wdata[HOST_W-1:MEM_W];

  bk_nib_store #(.DEPTH(CLK_DEPTH), .W(CLK_W)) u_nib (
    .clk    (clk),
    .rst    (rst),
    .ld_ptr (wr_go && sel_e == SEL_NADDR),
    .ptr_in (wdata[PW-1:0]),
    .wr     (wr_go && sel_e == SEL_NDATA),
    .rd     (rd_go && sel_e == SEL_NDATA),
    .wdata  (wdata[CLK_W-1:0]),
    .ptr    (nib_ptr),
    .q      (nib_q)
  );

  bk_byte_store #(.DEPTH(MEM_DEPTH), .W(MEM_W), .IN_W(HOST_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .ld_addr (wr_go && sel_e == SEL_MADDR),
    .addr_in (wdata),
    .wr      (wr_go && sel_e == SEL_MDATA),
    .rd      (rd_go && sel_e == SEL_MDATA),
    .wdata   (wdata[MEM_W-1:0]),
    .addr    (mem_addr),
    .q       (byte_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SEL_MADDR;
      blk_q    <= 1'b1;
      ptr_snap <= '0;
      batt_en  <= 1'b1;
    end else begin
      batt_en <= ifc_clr;
      if (req && !we) begin
        sel_q    <= sel_e;
        blk_q    <= ifc_clr;
        ptr_snap <= nib_ptr;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!blk_q) begin
      unique case (sel_q)
        SEL_NADDR: rdata = {{PAD_P{1'b0}}, ptr_snap};
        SEL_NDATA: rdata = {{PAD_D{1'b0}}, nib_q};
        SEL_MADDR: rdata = '0;
        SEL_MDATA: rdata = byte_q;
      endcase
    end
  end
endmodule

// File: rtl/bk_store_chk.sv
module bk_store_chk #(
  parameter int PW     = 4,
  parameter int AW     = 11,
  parameter int HOST_W = 16,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ifc_clr,
  input logic              req,
  input logic              we,
  input logic [1:0]        sel,
  input logic [HOST_W-1:0] wdata,
  input logic [DW-1:0]     rdata,
  input logic              batt_en,
  input logic [PW-1:0]     nib_ptr,
  input logic [AW-1:0]     mem_addr
);
  // R10
  batt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> batt_en == $past(ifc_clr));

  // R9
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !we && ifc_clr) |=> rdata == '0);

  // R8
  clr_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ifc_clr |=> $stable(nib_ptr));

  // R8
  clr_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ifc_clr |=> $stable(mem_addr));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ifc_clr && sel == 2'd1 && nib_ptr == {PW{1'b1}}) |=> nib_ptr == '0);

  // R6
  addr_invert_chk: assert property (@(posedge clk) disable iff (rst)
    (req && we && !ifc_clr && sel == 2'd2) |=> mem_addr == ~$past(wdata[AW-1:0]));

  // R7
  mem_addr_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (req && sel == 2'd3) |=> $stable(mem_addr));

  // R11
  maddr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !we && sel == 2'd2) |=> rdata == '0);
endmodule

bind bkup_store_ctrl bk_store_chk #(
  .PW(PW), .AW(AW), .HOST_W(HOST_W), .DW(MEM_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ifc_clr  (ifc_clr),
  .req      (req),
  .we       (we),
  .sel      (sel),
  .wdata    (wdata),
  .rdata    (rdata),
  .batt_en  (batt_en),
  .nib_ptr  (nib_ptr),
  .mem_addr (mem_addr)
);

// File: tb/tb_bkup_store_ctrl.sv
module tb_bkup_store_ctrl;
  localparam int MDEP = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ifc_clr = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        batt_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bkup_store_ctrl #(.CLK_DEPTH(16), .CLK_W(4), .MEM_DEPTH(MDEP), .MEM_W(8), .HOST_W(16)) dut (
    .clk(clk), .rst(rst), .ifc_clr(ifc_clr), .req(req), .we(we),
    .sel(sel), .wdata(wdata), .rdata(rdata), .batt_en(batt_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] s, input logic w, input logic [15:0] d);
    @(negedge clk);
    sel = s; we = w; wdata = d; req = 1'b1;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  function automatic logic [3:0] npat(input int i);
    return 4'((i * 7 + 3) & 15);
  endfunction

  function automatic logic [7:0] mpat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 rdata in reset", rdata, 8'h00);
    chk("R1 batt_en in reset", {7'd0, batt_en}, 8'h01);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 rdata after reset", rdata, 8'h00);
    op(2'd0, 1'b0, 16'h0);
    chk("R1 pointer after reset", rdata, 8'h00);

    // R2: upper bits of the pointer write are ignored
    op(2'd0, 1'b1, 16'hABC5);
    op(2'd0, 1'b0, 16'h0);
    chk("R2 pointer load", rdata, 8'h05);

    // R3 / R5: stream 16 nibbles from 5, wrapping through 15 -> 0
    for (int i = 0; i < 16; i++) op(2'd1, 1'b1, {12'hFED, npat((5 + i) % 16)});
    op(2'd0, 1'b0, 16'h0);
    chk("R5 pointer back at start after 16 writes", rdata, 8'h05);

    // R4: stream read from 0 over the whole store
    op(2'd0, 1'b1, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      op(2'd1, 1'b0, 16'h0);
      chk($sformatf("R3 R4 nibble %0d", i), rdata, {4'd0, npat(i)});
    end
    op(2'd0, 1'b0, 16'h0);
    chk("R5 pointer wrapped to 0 after reads", rdata, 8'h00);

    // R6 / R7: every memory cell, junk in upper address bits
    for (int a = 0; a < MDEP; a++) begin
      op(2'd2, 1'b1, ~16'(((a * 5 + 1) << 6) | a));
      op(2'd3, 1'b1, {8'h5A, mpat(a)});
    end
    for (int a = MDEP - 1; a >= 0; a--) begin
      op(2'd2, 1'b1, ~16'(((a * 3 + 2) << 6) | a));
      op(2'd3, 1'b0, 16'h0);
      chk($sformatf("R6 R7 byte %0d", a), rdata, mpat(a));
      op(2'd3, 1'b0, 16'h0);
      chk($sformatf("R7 repeat read %0d no increment", a), rdata, mpat(a));
    end
    // R11
    op(2'd2, 1'b0, 16'h0);
    chk("R11 address read is zero", rdata, 8'h00);

    // R10
    @(negedge clk); ifc_clr = 1'b1;
    @(posedge clk); #1;
    chk("R10 batt_en rises", {7'd0, batt_en}, 8'h01);

    // R8: writes under clear
    op(2'd0, 1'b1, 16'h0009);
    op(2'd1, 1'b1, 16'h000F);
    op(2'd2, 1'b1, ~16'd7);
    op(2'd3, 1'b1, 16'h00EE);
    // R9: reads under clear return zero, no pointer move
    op(2'd1, 1'b0, 16'h0);
    chk("R9 clock read under clear", rdata, 8'h00);
    op(2'd3, 1'b0, 16'h0);
    chk("R9 memory read under clear", rdata, 8'h00);
    @(negedge clk); ifc_clr = 1'b0;
    @(posedge clk); #1;
    chk("R10 batt_en falls", {7'd0, batt_en}, 8'h00);

    op(2'd0, 1'b0, 16'h0);
    chk("R8 R9 pointer unchanged by clear", rdata, 8'h00);
    op(2'd1, 1'b0, 16'h0);
    chk("R8 clock cell 0 kept", rdata, {4'd0, npat(0)});
    op(2'd3, 1'b0, 16'h0);
    chk("R8 memory address and byte kept", rdata, mpat(0));
    op(2'd2, 1'b1, ~16'd7);
    op(2'd3, 1'b0, 16'h0);
    chk("R8 byte 7 kept", rdata, mpat(7));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule